// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor with 3-Bit Opcodes

This block is a small stored-program processor built around a single accumulator. Each instruction is one memory word: a 3-bit opcode on top and a 5-bit field below it. For seven of the eight opcodes the field is a direct memory address. Opcode zero instead treats the field as a sub-code that selects an instruction with an implied operand. Code and data share one 32-word memory held inside the block.

Every instruction passes through three clocked phases. The first phase reads the instruction word at the program counter. The second phase advances the program counter and selects the operation. The third phase performs it. A single return register supports one level of subroutine call. An 8-bit keyboard input feeds the accumulator, and an 8-bit LED register shows it. A halt instruction parks the sequencer until reset.

While reset is held, the surrounding logic writes the program into the memory through a load port. Reset is then released and the processor runs from address 0.

Top module: `tiny_acc_cpu`

## Requirements
- R1: An instruction word holds the opcode in bits [7:5] and the field in bits [4:0]. The opcodes 001 store A (STA), 010 AND, 011 add with carry (ADC), 100 jump if C set (JC), 101 jump if Z clear (JNZ), 110 call and 111 load A (LDA) each use the field as a direct memory address.
- R2: Under opcode 000 the field selects the operation. 00000 no-op, 00001 invert A, 00010 rotate A right (A <= {A[0],A[7:1]}), 00011 rotate A left (A <= {A[6:0],A[7]}), 00100 A <= keyboard, 00101 LED <= A, 00110 clear A, 00111 clear C, 01000 increment A, 01001 decrement A, 01010 return, 11111 halt. Every other sub-code is a no-op.
- R3: Every instruction other than halt takes exactly three clocks: fetch, decode, execute. PC increments (mod 32) at the end of decode. The effects of the instruction appear at the end of execute.
- R4: While reset is asserted, PC, A, C, Z, LED, the return register and the halted output all read 0.
- R5: ADC sets {C,A} to A + M[a] + C. Every instruction that writes A sets Z to (A==0). Only ADC and clear-C change C. Increment and decrement wrap modulo 256.
- R6: JC loads PC with a when C=1, and JNZ loads PC with a when Z=0. Otherwise execution continues with the next word.
- R7: CALL saves the already incremented PC in the single return register and jumps to a. RET loads PC from that register. A second CALL overwrites the saved value, with no error indication.
- R8: STA writes A into M[a], and later loads and ANDs from a see that value.
- R9: After halt is decoded, halted_o is 1 from the second clock of that instruction onward. PC stays at the halt address + 1, and only reset clears the halted state.
- R10: The load port writes memory only while reset is asserted. A load strobe while the processor runs has no effect.
- R11: LED changes only on the LED-output sub-code and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Memory write strobe for program loading, honoured only during reset |
| load_addr_i | input | 5 | Memory address for program loading |
| load_data_i | input | 8 | Memory word for program loading |
| kbd_i | input | 8 | Keyboard input value |
| led_o | output | 8 | LED output register |
| halted_o | output | 1 | High while the sequencer is stopped |
| pc_o | output | 5 | Program counter |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag C |
| zero_o | output | 1 | Zero flag Z |

## Verification
The bench builds the block with its default 5-bit field, which gives an 8-bit word and a 32-word memory. With these values the halt code is the all-ones field, the full sub-code table can be reached, and the 8-bit carry out of ADC can be exercised. A behavioural interpreter in the bench steps through the fetch, decode and execute phases and is compared against PC, A, C, Z, LED and halted on every clock. Three programs are run: a counting loop that ends with 19 on the LEDs, a program covering calls and the overwritten return address, and a program covering carry-in and wraparound.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

   localparam logic [2:0] OPC_EXT  = 3'd0;
   localparam logic [2:0] OPC_STA  = 3'd1;
   localparam logic [2:0] OPC_AND  = 3'd2;
   localparam logic [2:0] OPC_ADC  = 3'd3;
   localparam logic [2:0] OPC_JC   = 3'd4;
   localparam logic [2:0] OPC_JNZ  = 3'd5;
   localparam logic [2:0] OPC_CALL = 3'd6;
   localparam logic [2:0] OPC_LDA  = 3'd7;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_HALT   = 2'd3
   } seq_state_e;

   typedef enum logic [4:0] {
      I_NOP, I_NOT, I_ROR, I_ROL, I_IN, I_OUT, I_CLRA, I_CLRC,
      I_INC, I_DEC, I_RET, I_HLT, I_STA, I_AND, I_ADC, I_JC,
      I_JNZ, I_CALL, I_LDA
   } instr_e;

endpackage

// File: rtl/acc_cpu_dec.sv
`timescale 1ns/1ps
module acc_cpu_dec
   import acc_cpu_pkg::*;
#(
   parameter int ADR_W = 5
) (
   input  logic [2:0]       op_i,
   input  logic [ADR_W-1:0] fld_i,
   output instr_e           ins_o
);

   logic hi_zero;

   generate
      if (ADR_W == 5) begin : g_narrow
         assign hi_zero = 1'b1;
      end else begin : g_wide
         assign hi_zero = ~|fld_i[ADR_W-1:5];
      end
   endgenerate

   always_comb begin
      ins_o = I_NOP;
      case (op_i)
         OPC_EXT: begin
            if (&fld_i) begin
               ins_o = I_HLT;
            end else if (hi_zero) begin
               case (fld_i[4:0])
                  5'd1:    ins_o = I_NOT;
                  5'd2:    ins_o = I_ROR;
                  5'd3:    ins_o = I_ROL;
                  5'd4:    ins_o = I_IN;
                  5'd5:    ins_o = I_OUT;
                  5'd6:    ins_o = I_CLRA;
                  5'd7:    ins_o = I_CLRC;
                  5'd8:    ins_o = I_INC;
                  5'd9:    ins_o = I_DEC;
                  5'd10:   ins_o = I_RET;
                  default: ins_o = I_NOP;
               endcase
            end
         end
         OPC_STA:  ins_o = I_STA;
         OPC_AND:  ins_o = I_AND;
         OPC_ADC:  ins_o = I_ADC;
         OPC_JC:   ins_o = I_JC;
         OPC_JNZ:  ins_o = I_JNZ;
         OPC_CALL: ins_o = I_CALL;
         default:  ins_o = I_LDA;
      endcase
   end

endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int W = 8
) (
   input  instr_e         ins_i,
   input  logic [W-1:0]   acc_i,
   input  logic [W-1:0]   mem_i,
   input  logic [W-1:0]   kbd_i,
   input  logic           c_i,
   output logic [W-1:0]   acc_o,
   output logic           acc_we_o,
   output logic           c_o,
   output logic           c_we_o
);

   logic [W-1:0] ror_v;
   logic [W-1:0] rol_v;
   logic [W:0]   sum_v;

   generate
      for (genvar i = 0; i < W; i++) begin : g_rot
         assign ror_v[i] = acc_i[(i + 1) % W];
         assign rol_v[i] = acc_i[(i + W - 1) % W];
      end
   endgenerate

   assign sum_v = {1'b0, acc_i} + {1'b0, mem_i} + {{W{1'b0}}, c_i};

   always_comb begin
      acc_o    = acc_i;
      acc_we_o = 1'b1;
      c_o      = c_i;
      c_we_o   = 1'b0;
      case (ins_i)
         I_NOT:  acc_o = ~acc_i;
         I_ROR:  acc_o = ror_v;
         I_ROL:  acc_o = rol_v;
         I_IN:   acc_o = kbd_i;
         I_CLRA: acc_o = '0;
         I_INC:  acc_o = acc_i + 1'b1;
         I_DEC:  acc_o = acc_i - 1'b1;
         I_AND:  acc_o = acc_i & mem_i;
         I_LDA:  acc_o = mem_i;
         I_ADC: begin
            acc_o  = sum_v[W-1:0];
            c_o    = sum_v[W];
            c_we_o = 1'b1;
         end
         I_CLRC: begin
            acc_we_o = 1'b0;
            c_o      = 1'b0;
            c_we_o   = 1'b1;
         end
         default: acc_we_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ram.sv
`timescale 1ns/1ps
module acc_cpu_ram #(
   parameter int AW = 5,
   parameter int W  = 8
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  instr_e     ins_i,
   output seq_state_e state_o
);

   seq_state_e state_q;
   seq_state_e state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: state_d = (ins_i == I_HLT) ? ST_HALT : ST_EXEC;
         ST_EXEC:   state_d = ST_FETCH;
         default:   state_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R9
   AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R3
   AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC) |=> (state_q == ST_FETCH)); // R3

endmodule

// File: rtl/tiny_acc_cpu.sv
`timescale 1ns/1ps
module tiny_acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_we_i,
   input  logic [ADR_W-1:0]     load_addr_i,
   input  logic [ADR_W+2:0]     load_data_i,
   input  logic [ADR_W+2:0]     kbd_i,
   output logic [ADR_W+2:0]     led_o,
   output logic                 halted_o,
   output logic [ADR_W-1:0]     pc_o,
   output logic [ADR_W+2:0]     acc_o,
   output logic                 carry_o,
   output logic                 zero_o
);

   localparam int OPC_W  = 3;
   localparam int DATA_W = OPC_W + ADR_W;

   generate
      if (ADR_W < 5 || ADR_W > 8) begin : g_bad_width
         $error("tiny_acc_cpu: ADR_W must lie between 5 and 8");
      end
   endgenerate

   seq_state_e         state_q;
   instr_e             ins;
   logic [ADR_W-1:0]   pc_q;
   logic [ADR_W-1:0]   ad_q;
   logic [ADR_W-1:0]   stk_q;
   logic [DATA_W-1:0]  ir_q;
   logic [DATA_W-1:0]  acc_q;
   logic [DATA_W-1:0]  led_q;
   logic               c_q;
   logic               z_q;

   logic [DATA_W-1:0]  ram_rd;
   logic [ADR_W-1:0]   ram_ra;
   logic [ADR_W-1:0]   ram_wa;
   logic [DATA_W-1:0]  ram_wd;
   logic               ram_we;
   logic               exec_en;

   logic [DATA_W-1:0]  alu_acc;
   logic               alu_acc_we;
   logic               alu_c;
   logic               alu_c_we;

   acc_cpu_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ins_i   (ins),
      .state_o (state_q)
   );

   acc_cpu_dec #(.ADR_W(ADR_W)) i_dec (
      .op_i  (ir_q[DATA_W-1:ADR_W]),
      .fld_i (ir_q[ADR_W-1:0]),
      .ins_o (ins)
   );

   acc_cpu_alu #(.W(DATA_W)) i_alu (
      .ins_i    (ins),
      .acc_i    (acc_q),
      .mem_i    (ram_rd),
      .kbd_i    (kbd_i),
      .c_i      (c_q),
      .acc_o    (alu_acc),
      .acc_we_o (alu_acc_we),
      .c_o      (alu_c),
      .c_we_o   (alu_c_we)
   );

   assign exec_en = (state_q == ST_EXEC);
   assign ram_ra  = (state_q == ST_FETCH) ? pc_q : ad_q;
   assign ram_we  = (!rst_n && load_we_i) || (exec_en && ins == I_STA);
   assign ram_wa  = rst_n ? ad_q  : load_addr_i;
   assign ram_wd  = rst_n ? acc_q : load_data_i;

   acc_cpu_ram #(.AW(ADR_W), .W(DATA_W)) i_ram (
      .clk     (clk),
      .we_i    (ram_we),
      .waddr_i (ram_wa),
      .wdata_i (ram_wd),
      .raddr_i (ram_ra),
      .rdata_o (ram_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ad_q  <= '0;
         stk_q <= '0;
         ir_q  <= '0;
         acc_q <= '0;
         led_q <= '0;
         c_q   <= 1'b0;
         z_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_FETCH: begin
               ir_q <= ram_rd;
               ad_q <= pc_q;
            end
            ST_DECODE: begin
               pc_q <= pc_q + 1'b1;
               ad_q <= ir_q[ADR_W-1:0];
            end
            ST_EXEC: begin
               if (alu_acc_we) begin
                  acc_q <= alu_acc;
                  z_q   <= ~|alu_acc;
               end
               if (alu_c_we) begin
                  c_q <= alu_c;
               end
               case (ins)
                  I_OUT:  led_q <= acc_q;
                  I_JC:   if (c_q)  pc_q <= ad_q;
                  I_JNZ:  if (!z_q) pc_q <= ad_q;
                  I_CALL: begin
                     stk_q <= pc_q;
                     pc_q  <= ad_q;
                  end
                  I_RET:  pc_q <= stk_q;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   assign led_o    = led_q;
   assign halted_o = (state_q == ST_HALT);
   assign pc_o     = pc_q;
   assign acc_o    = acc_q;
   assign carry_o  = c_q;
   assign zero_o   = z_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DECODE) |=> (pc_q == ADR_W'($past(pc_q) + 1'b1))); // R3
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_EXEC) |=> $stable(acc_q)); // R3
   AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> $stable(pc_q)); // R9
   AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && ins == I_CALL) |=> (stk_q == $past(pc_q) && pc_q == $past(ad_q))); // R7
   AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!(exec_en && (ins == I_ADC || ins == I_CLRC))) |=> $stable(c_q)); // R5
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(exec_en && ins == I_OUT)) |=> $stable(led_q)); // R11
   AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && alu_acc_we) |=> (z_q == (acc_q == '0))); // R5

endmodule

// File: tb/test_tiny_acc_cpu.sv
`timescale 1ns/1ps
module test_tiny_acc_cpu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_we = 1'b0;
   logic [4:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic [7:0] kbd = '0;
   logic [7:0] led;
   logic       halted;
   logic [4:0] pc;
   logic [7:0] acc;
   logic       carry;
   logic       zero;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_en = 1'b0;

   logic [7:0] prog [32];

   // reference model state
   logic [7:0] m_mem [32];
   logic [4:0] m_pc, m_stk;
   logic [7:0] m_a, m_led, m_ir;
   logic       m_c, m_z, m_halt;
   int         m_ph;

   always #2.5 clk = ~clk;

   tiny_acc_cpu i_tiny_acc_cpu (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_we_i   (load_we),
      .load_addr_i (load_addr),
      .load_data_i (load_data),
      .kbd_i       (kbd),
      .led_o       (led),
      .halted_o    (halted),
      .pc_o        (pc),
      .acc_o       (acc),
      .carry_o     (carry),
      .zero_o      (zero)
   );

   task automatic m_seta(input logic [7:0] v);
      m_a = v;
      m_z = (v == 8'h00);
   endtask

   task automatic m_exec();
      logic [2:0] op;
      logic [4:0] f;
      logic [8:0] s;
      op = m_ir[7:5];
      f  = m_ir[4:0];
      case (op)
         3'd0: case (f)
            5'd1:  m_seta(~m_a);
            5'd2:  m_seta({m_a[0], m_a[7:1]});
            5'd3:  m_seta({m_a[6:0], m_a[7]});
            5'd4:  m_seta(kbd);
            5'd5:  m_led = m_a;
            5'd6:  m_seta(8'h00);
            5'd7:  m_c = 1'b0;
            5'd8:  m_seta(m_a + 8'd1);
            5'd9:  m_seta(m_a - 8'd1);
            5'd10: m_pc = m_stk;
            default: ;
         endcase
         3'd1: m_mem[f] = m_a;
         3'd2: m_seta(m_a & m_mem[f]);
         3'd3: begin
            s = {1'b0, m_a} + {1'b0, m_mem[f]} + {8'd0, m_c};
            m_seta(s[7:0]);
            m_c = s[8];
         end
         3'd4: if (m_c) m_pc = f;
         3'd5: if (!m_z) m_pc = f;
         3'd6: begin
            m_stk = m_pc;
            m_pc  = f;
         end
         default: m_seta(m_mem[f]);
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = '0; m_stk = '0; m_a = '0; m_led = '0; m_ir = '0;
         m_c = 1'b0; m_z = 1'b0; m_halt = 1'b0; m_ph = 0;
         if (load_we) m_mem[load_addr] = load_data;
      end else if (!m_halt) begin
         case (m_ph)
            0: begin
               m_ir = m_mem[m_pc];
               m_ph = 1;
            end
            1: begin
               m_pc = m_pc + 5'd1;
               if (m_ir == 8'h1F) m_halt = 1'b1;
               else m_ph = 2;
            end
            default: begin
               m_exec();
               m_ph = 0;
            end
         endcase
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         bit bad;
         bad = 1'b0;
         n_cmp++;
         if (pc !== m_pc) begin
            $display("FAIL R3/R6 pc: got %0h expected %0h", pc, m_pc); bad = 1'b1;
         end
         if (acc !== m_a) begin
            $display("FAIL R2/R5 acc: got %0h expected %0h", acc, m_a); bad = 1'b1;
         end
         if (carry !== m_c) begin
            $display("FAIL R5 carry: got %0b expected %0b", carry, m_c); bad = 1'b1;
         end
         if (zero !== m_z) begin
            $display("FAIL R5 zero: got %0b expected %0b", zero, m_z); bad = 1'b1;
         end
         if (led !== m_led) begin
            $display("FAIL R11 led: got %0h expected %0h", led, m_led); bad = 1'b1;
         end
         if (halted !== m_halt) begin
            $display("FAIL R9 halted: got %0b expected %0b", halted, m_halt); bad = 1'b1;
         end
         if (bad) n_bad++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 32; i++) prog[i] = 8'h00;
   endtask

   task automatic load_prog();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         load_we   = 1'b1;
         load_addr = 5'(i);
         load_data = prog[i];
      end
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      chk({tag, " pc"}, int'(pc), 0);
      chk({tag, " acc"}, int'(acc), 0);
      chk({tag, " carry"}, int'(carry), 0);
      chk({tag, " zero"}, int'(zero), 0);
      chk({tag, " led"}, int'(led), 0);
      chk({tag, " halted"}, int'(halted), 0);
   endtask

   task automatic run_to_halt();
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (halted) break;
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      cmp_en = 1'b1;
      // program 1: count 1..19 in M[20], limit 20 in M[21]
      clear_prog();
      prog[0] = 8'h06; prog[1] = 8'h34; prog[2] = 8'hF4; prog[3] = 8'h08;
      prog[4] = 8'h34; prog[5] = 8'h05; prog[6] = 8'h01; prog[7] = 8'h07;
      prog[8] = 8'h75; prog[9] = 8'hA2; prog[10] = 8'hF4; prog[11] = 8'h05;
      prog[12] = 8'h1F; prog[21] = 8'h14;
      load_prog();
      @(negedge clk);
      check_reset_state("R4 first reset");
      run_to_halt();
      chk("R6/R8/R11 loop led", int'(led), 19);
      chk("R9 halted after loop", int'(halted), 1);
      chk("R9 pc after halt", int'(pc), 13);
      chk("R1/R5 acc after loop", int'(acc), 19);
      repeat (12) @(negedge clk);
      chk("R9 pc frozen", int'(pc), 13);
      chk("R9 still halted", int'(halted), 1);

      // program 2: extension ops, calls, overwritten return, memory ops
      clear_prog();
      prog[0] = 8'h04; prog[1] = 8'h02; prog[2] = 8'h03; prog[3] = 8'h01;
      prog[4] = 8'h74; prog[5] = 8'h87; prog[6] = 8'h1F; prog[7] = 8'hD8;
      prog[8] = 8'h05; prog[9] = 8'hDA; prog[10] = 8'h1F; prog[11] = 8'h06;
      prog[12] = 8'hF6; prog[13] = 8'h05; prog[14] = 8'h07; prog[15] = 8'h8A;
      prog[16] = 8'h09; prog[17] = 8'h0A; prog[20] = 8'h90; prog[21] = 8'h0C;
      prog[24] = 8'h08; prog[25] = 8'h0A; prog[26] = 8'hDC; prog[27] = 8'h1F;
      prog[28] = 8'h55; prog[29] = 8'h36; prog[30] = 8'hAB;
      kbd = 8'h81;
      load_prog();
      @(negedge clk);
      check_reset_state("R4 reset leaves halt");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      load_we = 1'b1; load_addr = 5'd21; load_data = 8'hFF;
      @(negedge clk);
      load_we = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (halted) break;
      end
      chk("R7 pc after overwritten return", int'(pc), 28);
      chk("R1/R8/R10 led from stored AND result", int'(led), 8'h0C);
      chk("R2 acc after decrement", int'(acc), 8'h0B);
      chk("R6 carry cleared before JC", int'(carry), 0);
      chk("R9 halted program 2", int'(halted), 1);

      // program 3: carry in and wraparound
      clear_prog();
      prog[0] = 8'h06; prog[1] = 8'h09; prog[2] = 8'h74; prog[3] = 8'h75;
      prog[4] = 8'h05; prog[5] = 8'h1F; prog[20] = 8'h01; prog[21] = 8'h05;
      load_prog();
      @(negedge clk);
      check_reset_state("R4 third reset");
      run_to_halt();
      chk("R5 acc with carry in", int'(acc), 6);
      chk("R5 carry after second add", int'(carry), 0);
      chk("R11 led program 3", int'(led), 6);
      chk("R9 pc program 3", int'(pc), 6);
      finish_run();
   end

endmodule